// File: doc/BRIEF.md
# Interrupt Entry and Acknowledge Sequencer

This block is the interrupt-control slice of a 32-bit soft processor core. It watches an external interrupt request, the core's instruction-boundary strobe and the return-from-interrupt strobe from the decoder. It owns the interrupt-enable, user-mode and virtual-mode status bits, and the saved copies of the two mode bits. When it accepts an interrupt, in that same cycle it gives the pipeline a redirect target, a link-register write of the current PC into r14, and a pulse that drops any outstanding load/store reservation. At the next edge it updates the status bits.

The block reports handling events to an external interrupt controller on a 2-bit acknowledge port. Each code appears for one cycle after the edge that records the event, and the port then goes back to idle. The redirect target comes from one of two variants, chosen at elaboration. One is a fixed entry point at a parameterised base plus 0x10. The other is a fast vectored variant in which the controller supplies the handler address.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous active-low reset, the acknowledge port reads 00 and the interrupt-enable, user-mode, virtual-mode bits and their saved copies are all 0.
- R2: An interrupt is accepted (redirect_valid_o high, combinationally in the same cycle) only when the request, the interrupt-enable bit and the instruction-boundary strobe are all 1.
- R3: In the fixed variant (FAST_MODE=0) the redirect target is VEC_BASE + 0x10.
- R4: On acceptance, link_we_o is 1, link_idx_o is 14 and link_data_o equals cur_pc_i. Otherwise link_we_o is 0.
- R5: At the edge that accepts an interrupt, interrupt-enable is cleared, user-mode is copied into its saved copy and cleared, and virtual-mode is copied into its saved copy and cleared.
- R6: resv_clr_o is high exactly in the cycles in which an interrupt is accepted.
- R7: In the cycle after an acceptance edge, the acknowledge port reads 01.
- R8: A return from interrupt sets interrupt-enable to 1 and restores user-mode and virtual-mode from their saved copies. In the following cycle the acknowledge port reads 10, never 11.
- R9: A status write that takes interrupt-enable from 0 to 1 gives 11 on the acknowledge port in the following cycle. A write while the bit is already 1 leaves the port at 00.
- R10: Each acknowledge code lasts one cycle. With no new event the port returns to 00.
- R11: When an interrupt is accepted in the same cycle as a return from interrupt or a status write, only the interrupt entry takes effect (acknowledge 01, entry status updates).
- R12: In the fast variant (FAST_MODE=1) the redirect target equals ctl_vec_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request from the controller |
| ctl_vec_addr_i | input | 32 | Handler address supplied by the controller (fast variant) |
| at_boundary_i | input | 1 | Core is between instructions; any multi-cycle operation has completed |
| cur_pc_i | input | 32 | PC of the instruction about to be issued |
| rti_exec_i | input | 1 | Return-from-interrupt instruction executes this cycle |
| msr_wr_en_i | input | 1 | Status register write this cycle |
| msr_wr_ie_i | input | 1 | Written interrupt-enable value |
| msr_wr_um_i | input | 1 | Written user-mode value |
| msr_wr_vm_i | input | 1 | Written virtual-mode value |
| redirect_valid_o | output | 1 | Interrupt accepted; redirect the fetch |
| redirect_pc_o | output | 32 | Handler address |
| link_we_o | output | 1 | Write the return address to the register file |
| link_idx_o | output | 5 | Link register index (14) |
| link_data_o | output | 32 | Return address |
| resv_clr_o | output | 1 | Drop the load/store reservation |
| irq_ack_o | output | 2 | Acknowledge code to the controller |
| ie_o | output | 1 | Interrupt-enable bit |
| um_o | output | 1 | User-mode bit |
| ums_o | output | 1 | Saved user-mode bit |
| vm_o | output | 1 | Virtual-mode bit |
| vms_o | output | 1 | Saved virtual-mode bit |

## Verification
The bench collides an accepted interrupt with a return and a status write in the same cycle. A design with the wrong priority would show 10 or 11 on the acknowledge port, or would leave interrupt-enable set inside the handler. It sends a request while the boundary strobe is low, and a request while enable is clear, where a loose qualifier would redirect in the middle of an instruction. It also repeats a status write that sets an already-set enable bit, and returns from an interrupt while enable is clear. A design that detects levels instead of the 0-to-1 change would raise 11 on the repeated write, or add 11 on the return. It also checks that mode bits saved at entry come back on return, so a design that swaps the saved copies or never fills them gets caught.

// File: rtl/irq_seq_pkg.sv
// Package: shared codes and types for the interrupt entry sequencer.
// Assumes: a 2-bit acknowledge code, a 32-bit address space.
package irq_seq_pkg;

    localparam int ADDR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int LINK_REG = 14;

    // Codes on the acknowledge port
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'b00,
        ACK_ENTER  = 2'b01,
        ACK_RETURN = 2'b10,
        ACK_ENABLE = 2'b11
    } ack_code_e;

    // Status bits owned by the sequencer
    typedef struct packed {
        logic ie;
        logic um;
        logic ums;
        logic vm;
        logic vms;
    } irq_status_t;

endpackage

// File: rtl/irq_event_arb.sv
// Module: irq_event_arb
// Decides which of entry, return or status write takes effect in a cycle,
// and which acknowledge code that event produces.
// Assumes: entry outranks return and status write; the others are squashed.
module irq_event_arb
    import irq_seq_pkg::*;
(
    input  logic      irq_req,
    input  logic      at_boundary,
    input  logic      ie_cur,
    input  logic      rti_exec,
    input  logic      msr_wr_en,
    input  logic      msr_wr_ie,
    output logic      take,
    output logic      do_rti,
    output logic      do_wr,
    output ack_code_e ack_code
);

    logic ie_rise;

    // Qualify the request and rank the events
    always_comb begin
        take    = irq_req && ie_cur && at_boundary;
        do_rti  = rti_exec && !take;
        do_wr   = msr_wr_en && !take && !rti_exec;
        ie_rise = do_wr && msr_wr_ie && !ie_cur;
    end

    // Pick the acknowledge code for the winning event
    always_comb begin
        if (take)         ack_code = ACK_ENTER;
        else if (do_rti)  ack_code = ACK_RETURN;
        else if (ie_rise) ack_code = ACK_ENABLE;
        else              ack_code = ACK_IDLE;
    end

endmodule

// File: rtl/irq_status_reg.sv
// Module: irq_status_reg
// Holds interrupt-enable, user/virtual mode bits and their saved copies.
// Assumes: at most one of take/do_rti/do_wr is high (arbiter guarantees).
module irq_status_reg
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        do_rti,
    input  logic        do_wr,
    input  logic        wr_ie,
    input  logic        wr_um,
    input  logic        wr_vm,
    output irq_status_t st
);

    irq_status_t st_q;

    // Update status on entry, return or software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (take) begin
            st_q.ie  <= 1'b0;
            st_q.ums <= st_q.um;
            st_q.um  <= 1'b0;
            st_q.vms <= st_q.vm;
            st_q.vm  <= 1'b0;
        end else if (do_rti) begin
            st_q.ie <= 1'b1;
            st_q.um <= st_q.ums;
            st_q.vm <= st_q.vms;
        end else if (do_wr) begin
            st_q.ie <= wr_ie;
            st_q.um <= wr_um;
            st_q.vm <= wr_vm;
        end
    end

    assign st = st_q;

    // R5: entry saves and clears the mode bits
    p_entry_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!st_q.ie && !st_q.um && !st_q.vm
                  && st_q.ums == $past(st_q.um) && st_q.vms == $past(st_q.vm)));

    // R8: return restores the saved copies
    p_rti_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_rti |=> (st_q.ie && st_q.um == $past(st_q.ums)
                    && st_q.vm == $past(st_q.vms)));

endmodule

// File: rtl/irq_vector_gen.sv
// Module: irq_vector_gen
// Forms the handler address and return address for an accepted interrupt.
// Assumes: FAST_MODE is fixed at elaboration; the return address is the PC
// of the instruction that would have issued.
module irq_vector_gen #(
    parameter int               ADDR_W    = 32,
    parameter bit               FAST_MODE = 1'b0,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] ctl_addr,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam logic [ADDR_W-1:0] ENTRY_OFS   = ADDR_W'(16);
    localparam logic [ADDR_W-1:0] FIXED_ENTRY = VEC_BASE + ENTRY_OFS;

    // Select the target source by variant
    generate
        if (FAST_MODE) begin : g_fast
            assign target = ctl_addr;
        end else begin : g_fixed
            assign target = FIXED_ENTRY;
        end
    endgenerate

    assign ret_addr = cur_pc;

endmodule

// File: rtl/irq_ack_gen.sv
// Module: irq_ack_gen
// Registers the acknowledge code so each event shows for exactly one cycle.
// Assumes: the code arrives combinationally in the event cycle.
module irq_ack_gen
    import irq_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ack_code_e code_in,
    output logic [1:0] ack
);

    ack_code_e ack_q;

    // Capture one code per cycle; idle when no event
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= ACK_IDLE;
        else        ack_q <= code_in;
    end

    assign ack = ack_q;

    // R10: a code with no new event behind it falls back to idle
    p_ack_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != ACK_IDLE && code_in == ACK_IDLE) |=> ack_q == ACK_IDLE);

endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Interrupt entry, return and acknowledge sequencing for a 32-bit core.
// Assumes: at_boundary_i is only high when no multi-cycle operation
// (e.g. divide) is in flight; the pipeline honours redirect in-cycle.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter bit          FAST_MODE = 1'b0,
    parameter logic [31:0] VEC_BASE  = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_req_i,
    input  logic [31:0] ctl_vec_addr_i,
    input  logic        at_boundary_i,
    input  logic [31:0] cur_pc_i,
    input  logic        rti_exec_i,
    input  logic        msr_wr_en_i,
    input  logic        msr_wr_ie_i,
    input  logic        msr_wr_um_i,
    input  logic        msr_wr_vm_i,
    output logic        redirect_valid_o,
    output logic [31:0] redirect_pc_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_data_o,
    output logic        resv_clr_o,
    output logic [1:0]  irq_ack_o,
    output logic        ie_o,
    output logic        um_o,
    output logic        ums_o,
    output logic        vm_o,
    output logic        vms_o
);

    logic        take, do_rti, do_wr;
    ack_code_e   ack_code;
    irq_status_t st;
    logic [31:0] target, ret_addr;

    irq_event_arb u_arb (
        .irq_req     (irq_req_i),
        .at_boundary (at_boundary_i),
        .ie_cur      (st.ie),
        .rti_exec    (rti_exec_i),
        .msr_wr_en   (msr_wr_en_i),
        .msr_wr_ie   (msr_wr_ie_i),
        .take        (take),
        .do_rti      (do_rti),
        .do_wr       (do_wr),
        .ack_code    (ack_code)
    );

    irq_status_reg u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .do_rti (do_rti),
        .do_wr  (do_wr),
        .wr_ie  (msr_wr_ie_i),
        .wr_um  (msr_wr_um_i),
        .wr_vm  (msr_wr_vm_i),
        .st     (st)
    );

    irq_vector_gen #(
        .ADDR_W    (ADDR_W),
        .FAST_MODE (FAST_MODE),
        .VEC_BASE  (VEC_BASE)
    ) u_vec (
        .cur_pc   (cur_pc_i),
        .ctl_addr (ctl_vec_addr_i),
        .target   (target),
        .ret_addr (ret_addr)
    );

    irq_ack_gen u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (ack_code),
        .ack     (irq_ack_o)
    );

    // Drive the pipeline side effects of an accepted interrupt
    always_comb begin
        redirect_valid_o = take;
        redirect_pc_o    = target;
        link_we_o        = take;
        link_idx_o       = REG_IDX_W'(LINK_REG);
        link_data_o      = ret_addr;
        resv_clr_o       = take;
    end

    assign ie_o  = st.ie;
    assign um_o  = st.um;
    assign ums_o = st.ums;
    assign vm_o  = st.vm;
    assign vms_o = st.vms;

    // R2: acceptance needs request, enable and boundary
    p_take_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> (irq_req_i && ie_o && at_boundary_i));

    // R7: acceptance is reported as entry on the next cycle
    p_entry_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |=> irq_ack_o == 2'b01);

    // R8: a return alone is reported as return, never as enable
    p_rti_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_exec_i && !redirect_valid_o) |=> irq_ack_o == 2'b10);

    // R9: the enable code only follows a 0-to-1 change of the enable bit
    p_enable_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_o == 2'b11) |-> (ie_o && !$past(ie_o)));

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int NVEC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        irq, bnd, rti, wr, wie, wum, wvm;
    logic [31:0] ctl_addr, pc;
    logic        rv, lwe, rclr, ie, um, ums, vm, vms;
    logic [31:0] rpc, ldata;
    logic [4:0]  lidx;
    logic [1:0]  ack;
    logic        f_rv, f_lwe, f_rclr, f_ie, f_um, f_ums, f_vm, f_vms;
    logic [31:0] f_rpc, f_ldata;
    logic [4:0]  f_lidx;
    logic [1:0]  f_ack;

    irq_entry_seq #(.FAST_MODE(1'b0), .VEC_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .ctl_vec_addr_i(ctl_addr),
        .at_boundary_i(bnd), .cur_pc_i(pc), .rti_exec_i(rti),
        .msr_wr_en_i(wr), .msr_wr_ie_i(wie), .msr_wr_um_i(wum), .msr_wr_vm_i(wvm),
        .redirect_valid_o(rv), .redirect_pc_o(rpc), .link_we_o(lwe),
        .link_idx_o(lidx), .link_data_o(ldata), .resv_clr_o(rclr),
        .irq_ack_o(ack), .ie_o(ie), .um_o(um), .ums_o(ums), .vm_o(vm), .vms_o(vms)
    );

    irq_entry_seq #(.FAST_MODE(1'b1), .VEC_BASE(BASE)) dut_fast_i (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .ctl_vec_addr_i(ctl_addr),
        .at_boundary_i(bnd), .cur_pc_i(pc), .rti_exec_i(rti),
        .msr_wr_en_i(wr), .msr_wr_ie_i(wie), .msr_wr_um_i(wum), .msr_wr_vm_i(wvm),
        .redirect_valid_o(f_rv), .redirect_pc_o(f_rpc), .link_we_o(f_lwe),
        .link_idx_o(f_lidx), .link_data_o(f_ldata), .resv_clr_o(f_rclr),
        .irq_ack_o(f_ack), .ie_o(f_ie), .um_o(f_um), .ums_o(f_ums), .vm_o(f_vm), .vms_o(f_vms)
    );

    // Vector: irq bnd rti wr wie wum wvm | take ack[1:0] ie um vm (after edge)
    typedef struct packed {
        logic irq, bnd, rti, wr, wie, wum, wvm, take;
        logic [1:0] ack;
        logic ie, um, vm;
    } vec_t;

    localparam logic [12:0] VECS [0:NVEC-1] = '{
        13'b1100000_0_00_000,  // request while enable clear: ignored (R2)
        13'b0001111_0_11_111,  // enable 0->1 write (R9)
        13'b0001111_0_00_111,  // enable already set (R9)
        13'b1000000_0_00_111,  // request off boundary (R2)
        13'b1100000_1_01_000,  // entry (R5, R7)
        13'b0000000_0_00_000,  // idle after entry (R10)
        13'b0010000_0_10_111,  // return restores (R8)
        13'b0000000_0_00_111,  // idle
        13'b1111000_1_01_000,  // entry collides with return and write (R11)
        13'b0001000_0_00_000,  // write leaves enable clear
        13'b0010000_0_10_111,  // return with enable clear: 10 only (R8)
        13'b0100000_0_00_111   // boundary without request (R2)
    };

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        irq = v.irq; bnd = v.bnd; rti = v.rti;
        wr = v.wr; wie = v.wie; wum = v.wum; wvm = v.wvm;
    endtask

    // Watchdog
    int cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        irq = 0; bnd = 0; rti = 0; wr = 0; wie = 0; wum = 0; wvm = 0;
        ctl_addr = 32'hCAFE_0100;
        pc = 32'h0000_4000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(ack == 2'b00, "R1 ack", 32'(ack), 0);
        check({ie, um, ums, vm, vms} == 5'b0, "R1 status", 32'({ie, um, ums, vm, vms}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            drive(v);
            pc = 32'h0000_4000 + 32'(i * 4);
            #1;
            check(rv == v.take, "R2 take", 32'(rv), 32'(v.take));
            check(rclr == v.take, "R6 resv", 32'(rclr), 32'(v.take));
            check(lwe == v.take, "R4 link_we", 32'(lwe), 32'(v.take));
            if (v.take) begin
                check(rpc == BASE + 32'h10, "R3 fixed target", rpc, BASE + 32'h10);
                check(f_rpc == ctl_addr, "R12 fast target", f_rpc, ctl_addr);
                check(ldata == pc, "R4 link data", ldata, pc);
                check(lidx == 5'd14, "R4 link idx", 32'(lidx), 14);
            end
            @(posedge clk);
            @(negedge clk);
            check(ack == v.ack, "R7 R8 R9 R10 R11 ack", 32'(ack), 32'(v.ack));
            check({ie, um, vm} == {v.ie, v.um, v.vm}, "R5 R8 R11 status",
                  32'({ie, um, vm}), 32'({v.ie, v.um, v.vm}));
            if (i == 4)
                check({ums, vms} == 2'b11, "R5 saved copies", 32'({ums, vms}), 3);
        end

        // R10: code lasts one cycle after a lone event
        drive('0);
        wr = 1; wie = 0;
        @(posedge clk); @(negedge clk);
        drive('0);
        wr = 1; wie = 1;
        @(posedge clk); @(negedge clk);
        check(ack == 2'b11, "R9 enable again", 32'(ack), 3);
        drive('0);
        @(posedge clk); @(negedge clk);
        check(ack == 2'b00, "R10 back to idle", 32'(ack), 0);

        // R12: fast target follows a changed controller address
        ctl_addr = 32'h1234_5678;
        irq = 1; bnd = 1;
        #1;
        check(f_rv && f_rpc == 32'h1234_5678, "R12 fast target", f_rpc, 32'h1234_5678);
        check(rpc == BASE + 32'h10, "R3 fixed ignores ctl", rpc, BASE + 32'h10);
        @(posedge clk); @(negedge clk);
        drive('0);

        // R1: reset mid-run clears status and ack
        wr = 1; wie = 1; wum = 1; wvm = 1;
        @(posedge clk); @(negedge clk);
        drive('0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check(ack == 2'b00 && {ie, um, vm} == 3'b0, "R1 mid reset",
              32'({ack, ie, um, vm}), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule